// File: doc/BRIEF.md
# Capability-Constrained Issue Port Binder

This block sits after renaming in an out-of-order core. Every cycle it receives a group of up to eight micro-operations. Each slot carries a valid bit and a 4-bit operation class. The block assigns each operation to an execution port that is able to run that class. There are three independent clusters: an integer cluster with six ports, a memory cluster, and a vector cluster with four ports. The memory cluster has three load-address ports, three store-address ports and two store-data ports. The ports within a cluster are not interchangeable. A fixed capability rule decides which classes each port may take.

Slots are served oldest first, in slot order. Some operations can run on either half of a cluster: plain integer ALU operations, vector floating-point add and vector integer operations. For these, the binder looks ahead at the younger slots of the same group. It keeps enough ports on each side free for the younger constrained operations that need them.

If an operation finds no eligible port, it is refused, and every younger operation of the same cluster is refused as well. The producer sees the refusals through the accepted mask and offers those slots again. All results are registered and appear one clock after the group is presented. For each port the block gives a valid bit, the slot index that was bound to it, and, for integer and vector ports, the bound class. A memory port's class follows from which kind of port it is.

Top module: `portBinder`

## Requirements
- R1: Class code 0 (ALU) may bind to any of the six integer ports. When no younger branch or shift/multiply in the group needs a port, ALU operations take free ports in the order 0, 2, 4, 1, 3, 5. An ALU operation avoids a port parity whose free count would fall below the number of younger valid operations that need that parity. It falls back to any free port only when both parities are reserved in this way.
- R2: Class code 1 (branch) binds only to even integer ports 0, 2, 4, lowest free first. At most three branches are accepted per cycle.
- R3: Class codes 2 (shift) and 3 (integer multiply) bind only to odd integer ports 1, 3, 5, lowest free first. At most three of them are accepted per cycle.
- R4: Each port carries at most one operation per cycle. The number of accepted slots equals the number of valid port outputs, and every valid port output names an accepted slot.
- R5: Class code 4 (load) binds only to load ports 0..2. Class code 5 (store address) binds only to store-address ports 0..2. Each kind is capped at three per cycle, even when ports of the other kind are idle.
- R6: Class code 6 (store data) binds only to the two store-data ports. A third store-data operation is refused.
- R7: Class codes 7 (fused multiply-add), 8 (vector multiply) and 9 (vector shift) bind only to vector ports 0 and 1. Class codes 10 (divide) and 11 (shuffle) bind only to vector ports 2 and 3.
- R8: Class codes 12 (floating-point add) and 13 (vector integer) may bind to any vector port. They use the same reservation rule as R1, with ports {0,1} as the low half and ports {2,3} as the high half, lowest port first.
- R9: When an operation is refused, every younger valid operation of the same cluster in that group is also refused, even if a port would suit it.
- R10: The clusters bind independently. A refusal or full cluster in one cluster never affects acceptance in another.
- R11: An invalid slot binds nothing and blocks nothing. A valid slot with an unused class code (14 or 15) is never accepted and blocks nothing.
- R12: Port outputs and the accepted mask are registered. They reflect the group presented at the previous rising edge, and they read all zero during reset and after a cycle with no valid slot.
- R13: Within a group, an older slot is bound before a younger one. Among eligible ports, an operation takes the lowest-numbered one that the rules above allow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | NUM_SLOTS | Per-slot valid |
| inClass | input | NUM_SLOTS x 4 | Per-slot operation class |
| accepted | output | NUM_SLOTS | Slots bound in the previous cycle |
| intValid | output | INT_PORTS | Integer port carries an operation |
| intSlot | output | INT_PORTS x SLOT_W | Slot bound to each integer port |
| intClass | output | INT_PORTS x 4 | Class bound to each integer port |
| vecValid | output | VEC_PORTS | Vector port carries an operation |
| vecSlot | output | VEC_PORTS x SLOT_W | Slot bound to each vector port |
| vecClass | output | VEC_PORTS x 4 | Class bound to each vector port |
| ldValid | output | LD_PORTS | Load port carries an operation |
| ldSlot | output | LD_PORTS x SLOT_W | Slot bound to each load port |
| staValid | output | STA_PORTS | Store-address port carries an operation |
| staSlot | output | STA_PORTS x SLOT_W | Slot bound to each store-address port |
| stdValid | output | STD_PORTS | Store-data port carries an operation |
| stdSlot | output | STD_PORTS x SLOT_W | Slot bound to each store-data port |

## Verification
The state inside this block lives for one cycle. It consists of the per-cluster free masks and hold flags that are carried from slot to slot. Any error in that state therefore appears one clock later, in the very next port and accepted outputs:

- A free mask that was not cleared shows up as two slots on one port, or as a port count that differs from the accepted count.
- A hold flag that leaks across clusters or is dropped shows up as a wrong bit in the accepted mask.
- A wrong reservation count shows up as a flexible operation on the wrong half, which makes a younger constrained operation refused when it should have been bound.

The directed groups are built so that each of these outcomes changes a specific bit that the bench checks.

// File: rtl/portBindPkg.sv
package portBindPkg;

  typedef enum logic [3:0] {
    OP_ALU    = 4'd0,
    OP_BR     = 4'd1,
    OP_SHIFT  = 4'd2,
    OP_IMUL   = 4'd3,
    OP_LOAD   = 4'd4,
    OP_STADDR = 4'd5,
    OP_STDATA = 4'd6,
    OP_VFMA   = 4'd7,
    OP_VMUL   = 4'd8,
    OP_VSHIFT = 4'd9,
    OP_VDIV   = 4'd10,
    OP_VSHUF  = 4'd11,
    OP_VFADD  = 4'd12,
    OP_VINT   = 4'd13
  } opClassE;

  typedef enum logic [1:0] {DOM_NONE, DOM_INT, DOM_MEM, DOM_VEC} domainE;

  // LOW/HIGH: even/odd integer ports, or lower/upper vector half
  typedef enum logic [2:0] {REQ_ANY, REQ_LOW, REQ_HIGH, REQ_LD, REQ_STA, REQ_STD} reqE;

  localparam int CNT_W = 4;  // supports up to 15 slots

  typedef struct packed {
    domainE           dom;
    reqE              req;
    logic [3:0]       cls;
    logic [CNT_W-1:0] youngLow;   // younger same-domain ops needing low side
    logic [CNT_W-1:0] youngHigh;  // younger same-domain ops needing high side
  } slotStrobeT;

endpackage

// File: rtl/portBindCtrl.sv
module portBindCtrl
  import portBindPkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic [NUM_SLOTS-1:0]      inValid,
  input  logic [NUM_SLOTS-1:0][3:0] inClass,
  output slotStrobeT [NUM_SLOTS-1:0] strobe
);

  domainE domArr [NUM_SLOTS];
  reqE    reqArr [NUM_SLOTS];

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      domArr[s] = DOM_NONE;
      reqArr[s] = REQ_ANY;
      if (inValid[s]) begin
        case (inClass[s])
          OP_ALU:                      begin domArr[s] = DOM_INT; reqArr[s] = REQ_ANY;  end
          OP_BR:                       begin domArr[s] = DOM_INT; reqArr[s] = REQ_LOW;  end
          OP_SHIFT, OP_IMUL:           begin domArr[s] = DOM_INT; reqArr[s] = REQ_HIGH; end
          OP_LOAD:                     begin domArr[s] = DOM_MEM; reqArr[s] = REQ_LD;   end
          OP_STADDR:                   begin domArr[s] = DOM_MEM; reqArr[s] = REQ_STA;  end
          OP_STDATA:                   begin domArr[s] = DOM_MEM; reqArr[s] = REQ_STD;  end
          OP_VFMA, OP_VMUL, OP_VSHIFT: begin domArr[s] = DOM_VEC; reqArr[s] = REQ_LOW;  end
          OP_VDIV, OP_VSHUF:           begin domArr[s] = DOM_VEC; reqArr[s] = REQ_HIGH; end
          OP_VFADD, OP_VINT:           begin domArr[s] = DOM_VEC; reqArr[s] = REQ_ANY;  end
          default:                     begin domArr[s] = DOM_NONE; reqArr[s] = REQ_ANY; end
        endcase
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      logic [CNT_W-1:0] cntLow;
      logic [CNT_W-1:0] cntHigh;
      cntLow  = '0;
      cntHigh = '0;
      for (int t = s + 1; t < NUM_SLOTS; t++) begin
        if (domArr[t] == domArr[s] && reqArr[t] == REQ_LOW)  cntLow  = cntLow + 1'b1;
        if (domArr[t] == domArr[s] && reqArr[t] == REQ_HIGH) cntHigh = cntHigh + 1'b1;
      end
      strobe[s].dom       = domArr[s];
      strobe[s].req       = reqArr[s];
      strobe[s].cls       = inClass[s];
      strobe[s].youngLow  = cntLow;
      strobe[s].youngHigh = cntHigh;
    end
  end

endmodule

// File: rtl/portBindPath.sv
module portBindPath
  import portBindPkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int INT_PORTS = 6,
  parameter int VEC_PORTS = 4,
  parameter int LD_PORTS  = 3,
  parameter int STA_PORTS = 3,
  parameter int STD_PORTS = 2,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  slotStrobeT [NUM_SLOTS-1:0]          strobe,
  output logic [NUM_SLOTS-1:0]                accepted,
  output logic [INT_PORTS-1:0]                intValid,
  output logic [INT_PORTS-1:0][SLOT_W-1:0]    intSlot,
  output logic [INT_PORTS-1:0][3:0]           intClass,
  output logic [VEC_PORTS-1:0]                vecValid,
  output logic [VEC_PORTS-1:0][SLOT_W-1:0]    vecSlot,
  output logic [VEC_PORTS-1:0][3:0]           vecClass,
  output logic [LD_PORTS-1:0]                 ldValid,
  output logic [LD_PORTS-1:0][SLOT_W-1:0]     ldSlot,
  output logic [STA_PORTS-1:0]                staValid,
  output logic [STA_PORTS-1:0][SLOT_W-1:0]    staSlot,
  output logic [STD_PORTS-1:0]                stdValid,
  output logic [STD_PORTS-1:0][SLOT_W-1:0]    stdSlot
);

  function automatic logic [15:0] allBits(int n);
    return (16'd1 << n) - 16'd1;
  endfunction

  function automatic logic [15:0] evenBits(int n);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < n; i += 2) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [15:0] INT_ALL  = allBits(INT_PORTS);
  localparam logic [15:0] INT_LOW  = evenBits(INT_PORTS);
  localparam logic [15:0] INT_HIGH = INT_ALL & ~INT_LOW;
  localparam logic [15:0] VEC_ALL  = allBits(VEC_PORTS);
  localparam logic [15:0] VEC_LOW  = allBits(VEC_PORTS / 2);
  localparam logic [15:0] VEC_HIGH = VEC_ALL & ~VEC_LOW;

  function automatic logic [15:0] firstOne(logic [15:0] m);
    return m & (~m + 16'd1);
  endfunction

  // One-hot grant for a cluster with two port sides and flexible operations
  function automatic logic [15:0] pickPort(logic [15:0] freeM, logic [15:0] lowM,
                                           logic [15:0] highM, reqE req,
                                           logic [CNT_W-1:0] yLow, logic [CNT_W-1:0] yHigh);
    logic [15:0] fl;
    logic [15:0] fh;
    fl = freeM & lowM;
    fh = freeM & highM;
    case (req)
      REQ_LOW:  return firstOne(fl);
      REQ_HIGH: return firstOne(fh);
      default: begin
        if ($countones(fl) > int'(yLow))       return firstOne(fl);
        else if ($countones(fh) > int'(yHigh)) return firstOne(fh);
        else if (fl != '0)                     return firstOne(fl);
        else                                   return firstOne(fh);
      end
    endcase
  endfunction

  logic [15:0] intFree, vecFree, ldFree, staFree, stdFree, grant;
  logic        intHold, vecHold, memHold;

  logic [NUM_SLOTS-1:0]             nAcc;
  logic [INT_PORTS-1:0]             nIntValid;
  logic [INT_PORTS-1:0][SLOT_W-1:0] nIntSlot;
  logic [INT_PORTS-1:0][3:0]        nIntClass;
  logic [VEC_PORTS-1:0]             nVecValid;
  logic [VEC_PORTS-1:0][SLOT_W-1:0] nVecSlot;
  logic [VEC_PORTS-1:0][3:0]        nVecClass;
  logic [LD_PORTS-1:0]              nLdValid;
  logic [LD_PORTS-1:0][SLOT_W-1:0]  nLdSlot;
  logic [STA_PORTS-1:0]             nStaValid;
  logic [STA_PORTS-1:0][SLOT_W-1:0] nStaSlot;
  logic [STD_PORTS-1:0]             nStdValid;
  logic [STD_PORTS-1:0][SLOT_W-1:0] nStdSlot;

  always_comb begin
    intFree = INT_ALL;
    vecFree = VEC_ALL;
    ldFree  = allBits(LD_PORTS);
    staFree = allBits(STA_PORTS);
    stdFree = allBits(STD_PORTS);
    intHold = 1'b0;
    vecHold = 1'b0;
    memHold = 1'b0;
    grant   = '0;
    nAcc = '0;
    nIntValid = '0; nIntSlot = '0; nIntClass = '0;
    nVecValid = '0; nVecSlot = '0; nVecClass = '0;
    nLdValid  = '0; nLdSlot  = '0;
    nStaValid = '0; nStaSlot = '0;
    nStdValid = '0; nStdSlot = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      case (strobe[s].dom)
        DOM_INT: if (!intHold) begin
          grant = pickPort(intFree, INT_LOW, INT_HIGH, strobe[s].req,
                           strobe[s].youngLow, strobe[s].youngHigh);
          if (grant == '0) intHold = 1'b1;
          else begin
            intFree = intFree & ~grant;
            nAcc[s] = 1'b1;
            for (int q = 0; q < INT_PORTS; q++) if (grant[q]) begin
              nIntValid[q] = 1'b1;
              nIntSlot[q]  = s[SLOT_W-1:0];
              nIntClass[q] = strobe[s].cls;
            end
          end
        end
        DOM_VEC: if (!vecHold) begin
          grant = pickPort(vecFree, VEC_LOW, VEC_HIGH, strobe[s].req,
                           strobe[s].youngLow, strobe[s].youngHigh);
          if (grant == '0) vecHold = 1'b1;
          else begin
            vecFree = vecFree & ~grant;
            nAcc[s] = 1'b1;
            for (int q = 0; q < VEC_PORTS; q++) if (grant[q]) begin
              nVecValid[q] = 1'b1;
              nVecSlot[q]  = s[SLOT_W-1:0];
              nVecClass[q] = strobe[s].cls;
            end
          end
        end
        DOM_MEM: if (!memHold) begin
          case (strobe[s].req)
            REQ_LD:  grant = firstOne(ldFree);
            REQ_STA: grant = firstOne(staFree);
            default: grant = firstOne(stdFree);
          endcase
          if (grant == '0) memHold = 1'b1;
          else begin
            nAcc[s] = 1'b1;
            case (strobe[s].req)
              REQ_LD: begin
                ldFree = ldFree & ~grant;
                for (int q = 0; q < LD_PORTS; q++) if (grant[q]) begin
                  nLdValid[q] = 1'b1;
                  nLdSlot[q]  = s[SLOT_W-1:0];
                end
              end
              REQ_STA: begin
                staFree = staFree & ~grant;
                for (int q = 0; q < STA_PORTS; q++) if (grant[q]) begin
                  nStaValid[q] = 1'b1;
                  nStaSlot[q]  = s[SLOT_W-1:0];
                end
              end
              default: begin
                stdFree = stdFree & ~grant;
                for (int q = 0; q < STD_PORTS; q++) if (grant[q]) begin
                  nStdValid[q] = 1'b1;
                  nStdSlot[q]  = s[SLOT_W-1:0];
                end
              end
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accepted <= '0;
      intValid <= '0; intSlot <= '0; intClass <= '0;
      vecValid <= '0; vecSlot <= '0; vecClass <= '0;
      ldValid  <= '0; ldSlot  <= '0;
      staValid <= '0; staSlot <= '0;
      stdValid <= '0; stdSlot <= '0;
    end else begin
      accepted <= nAcc;
      intValid <= nIntValid; intSlot <= nIntSlot; intClass <= nIntClass;
      vecValid <= nVecValid; vecSlot <= nVecSlot; vecClass <= nVecClass;
      ldValid  <= nLdValid;  ldSlot  <= nLdSlot;
      staValid <= nStaValid; staSlot <= nStaSlot;
      stdValid <= nStdValid; stdSlot <= nStdSlot;
    end
  end

endmodule

// File: rtl/portBinder.sv
module portBinder
  import portBindPkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int INT_PORTS = 6,
  parameter int VEC_PORTS = 4,
  parameter int LD_PORTS  = 3,
  parameter int STA_PORTS = 3,
  parameter int STD_PORTS = 2,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_SLOTS-1:0]             inValid,
  input  logic [NUM_SLOTS-1:0][3:0]        inClass,
  output logic [NUM_SLOTS-1:0]             accepted,
  output logic [INT_PORTS-1:0]             intValid,
  output logic [INT_PORTS-1:0][SLOT_W-1:0] intSlot,
  output logic [INT_PORTS-1:0][3:0]        intClass,
  output logic [VEC_PORTS-1:0]             vecValid,
  output logic [VEC_PORTS-1:0][SLOT_W-1:0] vecSlot,
  output logic [VEC_PORTS-1:0][3:0]        vecClass,
  output logic [LD_PORTS-1:0]              ldValid,
  output logic [LD_PORTS-1:0][SLOT_W-1:0]  ldSlot,
  output logic [STA_PORTS-1:0]             staValid,
  output logic [STA_PORTS-1:0][SLOT_W-1:0] staSlot,
  output logic [STD_PORTS-1:0]             stdValid,
  output logic [STD_PORTS-1:0][SLOT_W-1:0] stdSlot
);

  slotStrobeT [NUM_SLOTS-1:0] strobe;

  portBindCtrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .inValid(inValid),
    .inClass(inClass),
    .strobe (strobe)
  );

  portBindPath #(
    .NUM_SLOTS(NUM_SLOTS), .INT_PORTS(INT_PORTS), .VEC_PORTS(VEC_PORTS),
    .LD_PORTS(LD_PORTS), .STA_PORTS(STA_PORTS), .STD_PORTS(STD_PORTS), .SLOT_W(SLOT_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .accepted(accepted),
    .intValid(intValid), .intSlot(intSlot), .intClass(intClass),
    .vecValid(vecValid), .vecSlot(vecSlot), .vecClass(vecClass),
    .ldValid(ldValid), .ldSlot(ldSlot),
    .staValid(staValid), .staSlot(staSlot),
    .stdValid(stdValid), .stdSlot(stdSlot)
  );

endmodule

// File: rtl/portBindChk.sv
module portBindChk
  import portBindPkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int INT_PORTS = 6,
  parameter int VEC_PORTS = 4,
  parameter int LD_PORTS  = 3,
  parameter int STA_PORTS = 3,
  parameter int STD_PORTS = 2,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input logic                             clk,
  input logic                             rstN,
  input logic [NUM_SLOTS-1:0]             inValid,
  input logic [NUM_SLOTS-1:0][3:0]        inClass,
  input logic [NUM_SLOTS-1:0]             accepted,
  input logic [INT_PORTS-1:0]             intValid,
  input logic [INT_PORTS-1:0][SLOT_W-1:0] intSlot,
  input logic [INT_PORTS-1:0][3:0]        intClass,
  input logic [VEC_PORTS-1:0]             vecValid,
  input logic [VEC_PORTS-1:0][SLOT_W-1:0] vecSlot,
  input logic [VEC_PORTS-1:0][3:0]        vecClass,
  input logic [LD_PORTS-1:0]              ldValid,
  input logic [LD_PORTS-1:0][SLOT_W-1:0]  ldSlot,
  input logic [STA_PORTS-1:0]             staValid,
  input logic [STA_PORTS-1:0][SLOT_W-1:0] staSlot,
  input logic [STD_PORTS-1:0]             stdValid,
  input logic [STD_PORTS-1:0][SLOT_W-1:0] stdSlot
);

  // R4
  bound_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(accepted) == $countones({intValid, vecValid, ldValid, staValid, stdValid}));

  // R12
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|inValid) |=> (accepted == '0 && intValid == '0 && vecValid == '0));

  for (genvar p = 0; p < INT_PORTS; p++) begin : g_int
    // R4
    int_slot_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
      intValid[p] |-> accepted[intSlot[p]]);
    // R1
    int_class_dom_chk: assert property (@(posedge clk) disable iff (!rstN)
      intValid[p] |-> intClass[p] <= OP_IMUL);
    if (p % 2 == 1) begin : g_odd
      // R2
      br_even_only_chk: assert property (@(posedge clk) disable iff (!rstN)
        intValid[p] |-> intClass[p] != OP_BR);
    end else begin : g_even
      // R3
      shmul_odd_only_chk: assert property (@(posedge clk) disable iff (!rstN)
        intValid[p] |-> (intClass[p] != OP_SHIFT && intClass[p] != OP_IMUL));
    end
  end

  for (genvar p = 0; p < VEC_PORTS; p++) begin : g_vec
    if (p < VEC_PORTS / 2) begin : g_lo
      // R7
      vec_low_caps_chk: assert property (@(posedge clk) disable iff (!rstN)
        vecValid[p] |-> (vecClass[p] != OP_VDIV && vecClass[p] != OP_VSHUF));
    end else begin : g_hi
      // R7
      vec_high_caps_chk: assert property (@(posedge clk) disable iff (!rstN)
        vecValid[p] |-> (vecClass[p] != OP_VFMA && vecClass[p] != OP_VMUL &&
                         vecClass[p] != OP_VSHIFT));
    end
  end

endmodule

bind portBinder portBindChk #(
  .NUM_SLOTS(NUM_SLOTS), .INT_PORTS(INT_PORTS), .VEC_PORTS(VEC_PORTS),
  .LD_PORTS(LD_PORTS), .STA_PORTS(STA_PORTS), .STD_PORTS(STD_PORTS), .SLOT_W(SLOT_W)
) u_chk (.*);

// File: tb/portBinder_tb.sv
module portBinder_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0]      inValid = '0;
  logic [7:0][3:0] inClass = '0;
  logic [7:0]      accepted;
  logic [5:0]      intValid;
  logic [5:0][2:0] intSlot;
  logic [5:0][3:0] intClass;
  logic [3:0]      vecValid;
  logic [3:0][2:0] vecSlot;
  logic [3:0][3:0] vecClass;
  logic [2:0]      ldValid;
  logic [2:0][2:0] ldSlot;
  logic [2:0]      staValid;
  logic [2:0][2:0] staSlot;
  logic [1:0]      stdValid;
  logic [1:0][2:0] stdSlot;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  portBinder u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inClass(inClass), .accepted(accepted),
    .intValid(intValid), .intSlot(intSlot), .intClass(intClass),
    .vecValid(vecValid), .vecSlot(vecSlot), .vecClass(vecClass),
    .ldValid(ldValid), .ldSlot(ldSlot), .staValid(staValid), .staSlot(staSlot),
    .stdValid(stdValid), .stdSlot(stdSlot)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Present a group (slot0 class in the lowest nibble); return once outputs are registered
  task automatic issue(input logic [7:0] v, input logic [31:0] c);
    @(negedge clk);
    inValid = v;
    inClass = c;
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R12 reset accepted", 32'(accepted), 0);
    chk("R12 reset ports", 32'({intValid, vecValid, ldValid, staValid, stdValid}), 0);
  endtask

  task automatic testAluOrder();
    issue(8'h3F, 32'h0000_0000);
    chk("R1 six ALU accepted", 32'(accepted), 32'h3F);
    chk("R13 port2 gets slot1", 32'(intSlot[2]), 1);
    chk("R13 port1 gets slot3", 32'(intSlot[1]), 3);
    chk("R1 port5 gets slot5", 32'(intSlot[5]), 5);
  endtask

  task automatic testAluReserve();
    issue(8'h0F, 32'h0000_1110);
    chk("R1 ALU steered odd", 32'(intSlot[1]), 0);
    chk("R2 branch ports", 32'(intValid), 32'h17);
    chk("R2 port0 slot1", 32'(intSlot[0]), 1);
    chk("R2 port4 slot3", 32'(intSlot[4]), 3);
  endtask

  task automatic testBranchCap();
    issue(8'h3F, 32'h0040_1111);
    chk("R9 R2 accepted", 32'(accepted), 32'h27);
    chk("R2 even only", 32'(intValid), 32'h15);
    chk("R10 load bound", 32'(ldValid), 1);
    chk("R10 load slot", 32'(ldSlot[0]), 5);
  endtask

  task automatic testShiftCap();
    issue(8'h1F, 32'h0007_3232);
    chk("R3 accepted", 32'(accepted), 32'h17);
    chk("R3 odd only", 32'(intValid), 32'h2A);
    chk("R3 port5 slot2", 32'(intSlot[5]), 2);
    chk("R10 vector bound", 32'(vecValid), 1);
    chk("R10 vector slot", 32'(vecSlot[0]), 4);
  endtask

  task automatic testMemory();
    issue(8'h1F, 32'h0005_4444);
    chk("R5 R9 load cap", 32'(accepted), 32'h07);
    chk("R5 load ports", 32'(ldValid), 32'h7);
    chk("R9 store held", 32'(staValid), 0);
    issue(8'hFF, 32'h6655_5444);
    chk("R5 full mix", 32'(accepted), 32'hFF);
    chk("R5 sta slot", 32'(staSlot[0]), 3);
    chk("R6 std ports", 32'(stdValid), 32'h3);
    chk("R6 std slot", 32'(stdSlot[1]), 7);
    issue(8'h07, 32'h0000_0666);
    chk("R6 std cap", 32'(accepted), 32'h03);
  endtask

  task automatic testVector();
    issue(8'h0F, 32'h0000_D777);
    chk("R7 R9 fma cap", 32'(accepted), 32'h03);
    chk("R7 low pair", 32'(vecValid), 32'h3);
    issue(8'h0F, 32'h0000_DCBA);
    chk("R7 all four", 32'(accepted), 32'h0F);
    chk("R7 div on 2", 32'(vecSlot[2]), 0);
    chk("R7 shuf on 3", 32'(vecSlot[3]), 1);
    chk("R8 fadd on 0", 32'(vecSlot[0]), 2);
    chk("R8 vint on 1", 32'(vecSlot[1]), 3);
    issue(8'h07, 32'h0000_098C);
    chk("R8 fadd steered high", 32'(vecSlot[2]), 0);
    chk("R8 ports used", 32'(vecValid), 32'h7);
    chk("R7 vmul on 0", 32'(vecSlot[0]), 1);
  endtask

  task automatic testInvalid();
    issue(8'h1A, 32'h0001_E401);
    chk("R11 accepted", 32'(accepted), 32'h12);
    chk("R11 ALU port0", 32'(intSlot[0]), 1);
    chk("R11 branch port2", 32'(intSlot[2]), 4);
    chk("R11 invalid load", 32'(ldValid), 0);
  endtask

  task automatic testIdle();
    issue(8'h00, 32'h1111_1111);
    chk("R12 idle accepted", 32'(accepted), 0);
    chk("R12 idle ports", 32'({intValid, vecValid, ldValid, staValid, stdValid}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAluOrder();
    testAluReserve();
    testBranchCap();
    testShiftCap();
    testMemory();
    testVector();
    testInvalid();
    testIdle();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule